// File: doc/BRIEF.md
# Dynamic-Width Bus Cycle Sizer

This block turns one 32-bit transfer request from a core (byte-lane enables, write data, direction) into one or two cycles on an external data bus whose width is decided per cycle. The device answering a cycle reports a 16-bit port on `bus_size16` in the same clock in which it raises `bus_ready`. The block reads that input only then. A transfer that needs bytes from both halves on a 16-bit port is completed with a second cycle that the block issues by itself.

Write data is steered so that a narrow port always finds its bytes on the low lines. The high half of the write data also appears on the low half whenever no low byte is being written, and in every second cycle. Read data is gathered from the proper lines for each cycle. It is merged with the low half captured in an earlier cycle, and the result is handed to the core with a one-clock `done` pulse.

Top module: `bus_sizer`

## Requirements
- R1: While `rst_n` is low and after its release, `bus_cyc`, `done`, `bus_be` and `bus_wr` are 0 until a request is accepted.
- R2: A request raised while no transfer is in progress is accepted at a clock edge, and the first bus cycle is presented from the next clock with `bus_be` equal to the request's byte enables and `bus_wr` equal to its direction. The cycle's outputs hold steady until a clock in which `bus_ready` is high.
- R3: `bus_size16` is read only in a clock where `bus_cyc` and `bus_ready` are both high; its value in wait clocks has no effect. With `bus_size16` low, any request finishes in one cycle.
- R4: If `bus_size16` is high when the first cycle completes and at least one enable is set in each half (bits 1:0 and bits 3:2), a second cycle follows in the very next clock. Its `bus_be` bits 3:2 match the request and bits 1:0 are 0.
- R5: A request with enables only in bits 1:0 always finishes in a single cycle.
- R6: A write with enables only in bits 3:2 finishes in a single cycle even on a 16-bit port.
- R7: During write cycles all 32 data lines are driven. Bits 31:16 carry write data 31:16. Bits 15:0 carry write data 15:0 when the cycle enables a byte in bits 1:0; otherwise, including every second cycle, they carry write data 31:16. `bus_dout` is 0 during read cycles.
- R8: In a read cycle completed with `bus_size16` high, the bytes for lanes 3:2 are taken from `bus_din` 15:0, and `bus_din` 31:16 is ignored.
- R9: `done` pulses for one clock, in the clock after the last cycle completes. After a read, `rdata` holds the enabled bytes and 0 in lanes that were not enabled. `rdata` keeps its value across writes and idle time.
- R10: In a split read, the low lanes are captured from `bus_din` 15:0 when the first cycle completes, and appear in `rdata` together with the upper lanes from the second cycle.
- R11: The second cycle of a split read uses its own sampled `bus_size16`: if it is low, the upper lanes come from `bus_din` 31:16.
- R12: A request raised while a transfer is in progress is ignored and does not change the cycle on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request strobe |
| req_be | input | 4 | Core byte-lane enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Core write data |
| bus_cyc | output | 1 | A bus cycle is being presented |
| bus_wr | output | 1 | Current bus cycle is a write |
| bus_be | output | 4 | Byte enables of the current bus cycle |
| bus_dout | output | 32 | Data driven for write cycles |
| bus_din | input | 32 | Data returned for read cycles |
| bus_ready | input | 1 | Current bus cycle completes this clock |
| bus_size16 | input | 1 | 1 = 16-bit port answering, 0 = 32-bit |
| done | output | 1 | One-clock pulse when a transfer finishes |
| rdata | output | 32 | Assembled read data for the core |

## Verification
Two things can land in the same clock: the completion of a first cycle, with its size decision, and the capture of the low read half. The first cycle's ready then leads straight into the split second cycle, whose size may differ. The bench provokes this with split reads in which the second cycle reports a 16-bit port in one case and a 32-bit port in another, feeding different data words in the two cycles. It judges the result by whether each byte of `rdata` came from the expected cycle and line group. A second case sets a new request against a cycle held in wait states while `bus_size16` flips. The bench then checks that the presented enables stay as they were and that only the size seen in the ready clock counts.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2
   } bsz_state_e;

   // any enable set within a lane range
   function automatic logic any_set(input logic [15:0] v);
      return |v;
   endfunction
endpackage

// File: rtl/bsz_ctrl.sv
module bsz_ctrl
   import bsz_pkg::*;
#(
   parameter int NB = 4,
   localparam int HB = NB / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [NB-1:0] req_be,
   input  logic          req_write,
   input  logic          bus_ready,
   input  logic          bus_size16,
   output bsz_state_e    state,
   output logic [NB-1:0] be_q,
   output logic          wr_q,
   output logic          accept,
   output logic          split_fire,
   output logic          final_fire,
   output logic          done_q
);
   logic need_second;
   logic first_fire;
   logic second_fire;
   logic [15:0] lo_ext, hi_ext;

   always_comb begin
      lo_ext = '0;
      hi_ext = '0;
      lo_ext[HB-1:0] = be_q[HB-1:0];
      hi_ext[HB-1:0] = be_q[NB-1:HB];
   end

   assign need_second = bus_size16 && any_set(lo_ext) && any_set(hi_ext);
   assign accept      = (state == ST_IDLE) && req_valid;
   assign first_fire  = (state == ST_FIRST) && bus_ready;
   assign second_fire = (state == ST_SECOND) && bus_ready;
   assign split_fire  = first_fire && need_second;
   assign final_fire  = (first_fire && !need_second) || second_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         be_q   <= '0;
         wr_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= final_fire;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state <= ST_FIRST;
                  be_q  <= req_be;
                  wr_q  <= req_write;
               end
            end
            ST_FIRST: begin
               if (bus_ready) state <= need_second ? ST_SECOND : ST_IDLE;
            end
            ST_SECOND: begin
               if (bus_ready) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bsz_wsteer.sv
module bsz_wsteer #(
   parameter int DATA_W = 32,
   localparam int NB = DATA_W / 8,
   localparam int HB = NB / 2,
   localparam int HW = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [NB-1:0]     be_q,
   input  logic              second,
   input  logic              drive,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] wd_q;
   logic              mirror;

   always_ff @(posedge clk) begin
      if (!rst_n) wd_q <= '0;
      else if (accept) wd_q <= req_wdata;
   end

   // lower lines carry the upper half when no lower byte is in this cycle
   assign mirror = second || (be_q[HB-1:0] == '0);

   always_comb begin
      dout = '0;
      if (drive) begin
         dout[DATA_W-1:HW] = wd_q[DATA_W-1:HW];
         dout[HW-1:0]      = mirror ? wd_q[DATA_W-1:HW] : wd_q[HW-1:0];
      end
   end
endmodule

// File: rtl/bsz_rassm.sv
module bsz_rassm #(
   parameter int DATA_W    = 32,
   parameter bit ZERO_FILL = 1'b1,
   localparam int NB = DATA_W / 8,
   localparam int HB = NB / 2,
   localparam int HW = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              split_fire,
   input  logic              final_fire,
   input  logic              second,
   input  logic              wr_q,
   input  logic              bus_size16,
   input  logic [NB-1:0]     be_q,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] rdata
);
   logic [HW-1:0]     lo_hold;
   logic [DATA_W-1:0] src;
   logic [DATA_W-1:0] merged;

   always_ff @(posedge clk) begin
      if (!rst_n) lo_hold <= '0;
      else if (split_fire) lo_hold <= bus_din[HW-1:0];
   end

   // line group that feeds each half in the completing cycle
   always_comb begin
      src[DATA_W-1:HW] = bus_size16 ? bus_din[HW-1:0] : bus_din[DATA_W-1:HW];
      src[HW-1:0]      = second ? lo_hold : bus_din[HW-1:0];
   end

   for (genvar i = 0; i < NB; i++) begin : g_lane
      if (ZERO_FILL) begin : g_zero
         assign merged[8*i+:8] = be_q[i] ? src[8*i+:8] : 8'h00;
      end else begin : g_keep
         assign merged[8*i+:8] = be_q[i] ? src[8*i+:8] : rdata[8*i+:8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else if (final_fire && !wr_q) rdata <= merged;
   end

   logic unused_hb;
   assign unused_hb = (HB == 0);
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
   import bsz_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit ZERO_FILL = 1'b1,
   localparam int NB = DATA_W / 8,
   localparam int HB = NB / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [NB-1:0]     req_be,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              bus_cyc,
   output logic              bus_wr,
   output logic [NB-1:0]     bus_be,
   output logic [DATA_W-1:0] bus_dout,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              bus_ready,
   input  logic              bus_size16,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   if (DATA_W % 16 != 0 || DATA_W < 16 || DATA_W > 128) begin : g_bad_width
      $error("bus_sizer: DATA_W must be a multiple of 16 between 16 and 128");
   end

   bsz_state_e    state;
   logic [NB-1:0] be_q;
   logic          wr_q;
   logic          accept;
   logic          split_fire;
   logic          final_fire;
   logic          second;

   bsz_ctrl #(.NB(NB)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_be     (req_be),
      .req_write  (req_write),
      .bus_ready  (bus_ready),
      .bus_size16 (bus_size16),
      .state      (state),
      .be_q       (be_q),
      .wr_q       (wr_q),
      .accept     (accept),
      .split_fire (split_fire),
      .final_fire (final_fire),
      .done_q     (done)
   );

   assign second  = (state == ST_SECOND);
   assign bus_cyc = (state != ST_IDLE);
   assign bus_wr  = bus_cyc && wr_q;

   always_comb begin
      bus_be = '0;
      if (bus_cyc) begin
         bus_be = be_q;
         if (second) bus_be[HB-1:0] = '0;
      end
   end

   bsz_wsteer #(.DATA_W(DATA_W)) u_wsteer (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_wdata (req_wdata),
      .be_q      (be_q),
      .second    (second),
      .drive     (bus_wr),
      .dout      (bus_dout)
   );

   bsz_rassm #(.DATA_W(DATA_W), .ZERO_FILL(ZERO_FILL)) u_rassm (
      .clk        (clk),
      .rst_n      (rst_n),
      .split_fire (split_fire),
      .final_fire (final_fire),
      .second     (second),
      .wr_q       (wr_q),
      .bus_size16 (bus_size16),
      .be_q       (be_q),
      .bus_din    (bus_din),
      .rdata      (rdata)
   );
endmodule

// File: rtl/bsz_chk.sv
module bsz_chk #(
   parameter int DATA_W = 32,
   localparam int NB = DATA_W / 8,
   localparam int HB = NB / 2,
   localparam int HW = DATA_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_cyc,
   input logic              bus_wr,
   input logic [NB-1:0]     bus_be,
   input logic [DATA_W-1:0] bus_dout,
   input logic              bus_ready,
   input logic              bus_size16,
   input logic              done
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cyc |-> (bus_be == '0) && !bus_wr);

   // R4
   second_lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc && $past(bus_cyc && bus_ready) |-> (bus_be[HB-1:0] == '0));

   // R4
   split_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc && bus_ready && bus_size16 && (|bus_be[HB-1:0]) && (|bus_be[NB-1:HB])
      |=> bus_cyc);

   // R3
   wide_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc && bus_ready && !bus_size16 |=> done && !bus_cyc);

   // R5
   low_only_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc && bus_ready && (bus_be[NB-1:HB] == '0) |=> done && !bus_cyc);

   // R7
   mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && (bus_be[HB-1:0] == '0) |-> (bus_dout[HW-1:0] == bus_dout[DATA_W-1:HW]));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc && !bus_ready |=> bus_cyc && $stable(bus_be) && $stable(bus_dout));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind bus_sizer bsz_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_cyc    (bus_cyc),
   .bus_wr     (bus_wr),
   .bus_be     (bus_be),
   .bus_dout   (bus_dout),
   .bus_ready  (bus_ready),
   .bus_size16 (bus_size16),
   .done       (done)
);

// File: tb/sim_bus_sizer.sv
module sim_bus_sizer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_be = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        bus_cyc, bus_wr, done;
   logic [3:0]  bus_be;
   logic [31:0] bus_dout, rdata;
   logic [31:0] bus_din = '0;
   logic        bus_ready = 1'b0;
   logic        bus_size16 = 1'b0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   localparam logic [31:0] D1 = 32'hA1A2A3A4;
   localparam logic [31:0] D2 = 32'hB1B2B3B4;

   always #5 clk = ~clk;

   bus_sizer u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_be(req_be),
      .req_write(req_write), .req_wdata(req_wdata), .bus_cyc(bus_cyc),
      .bus_wr(bus_wr), .bus_be(bus_be), .bus_dout(bus_dout), .bus_din(bus_din),
      .bus_ready(bus_ready), .bus_size16(bus_size16), .done(done), .rdata(rdata)
   );

   // {be, write, size1, size2, ncyc[1:0], exp_rdata, wdata}
   localparam int NV = 11;
   localparam logic [72:0] TBL [NV] = '{
      {4'hF, 1'b0, 1'b0, 1'b0, 2'd1, 32'hA1A2A3A4, 32'h0},
      {4'hF, 1'b0, 1'b1, 1'b1, 2'd2, 32'hB3B4A3A4, 32'h0},
      {4'hC, 1'b0, 1'b1, 1'b1, 2'd1, 32'hA3A40000, 32'h0},
      {4'h3, 1'b0, 1'b1, 1'b1, 2'd1, 32'h0000A3A4, 32'h0},
      {4'h6, 1'b0, 1'b1, 1'b0, 2'd2, 32'h00B2A300, 32'h0},
      {4'h8, 1'b0, 1'b0, 1'b0, 2'd1, 32'hA1000000, 32'h0},
      {4'hE, 1'b0, 1'b1, 1'b1, 2'd2, 32'hB3B4A300, 32'h0},
      {4'hF, 1'b1, 1'b1, 1'b1, 2'd2, 32'h0,        32'h11223344},
      {4'hC, 1'b1, 1'b1, 1'b1, 2'd1, 32'h0,        32'h55667788},
      {4'h1, 1'b1, 1'b1, 1'b1, 2'd1, 32'h0,        32'h99AABBCC},
      {4'h3, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0,        32'hDEADBEEF}
   };

   task automatic chk(input bit ok, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   int ncyc;

   task automatic xfer(input logic [3:0] be, input logic wr, input logic s1,
                       input logic s2, input logic [31:0] wd);
      logic [31:0] exp_d;
      @(negedge clk);
      req_valid = 1'b1; req_be = be; req_write = wr; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      ncyc = 0;
      for (int k = 0; k < 6 && !done; k++) begin
         if (bus_cyc) begin
            if (ncyc == 0) begin
               chk(bus_be == be, "R2 first cycle enables", {28'h0, bus_be}, {28'h0, be});
               chk(bus_wr == wr, "R2 direction", {31'h0, bus_wr}, {31'h0, wr});
               exp_d = wr ? {wd[31:16], (be[1:0] == 2'b00) ? wd[31:16] : wd[15:0]} : 32'h0;
               chk(bus_dout == exp_d, "R6 R7 first cycle data lines", bus_dout, exp_d);
            end else begin
               chk(bus_be == (be & 4'hC), "R4 second cycle enables",
                   {28'h0, bus_be}, {28'h0, be & 4'hC});
               exp_d = wr ? {wd[31:16], wd[31:16]} : 32'h0;
               chk(bus_dout == exp_d, "R7 second cycle data lines", bus_dout, exp_d);
            end
            bus_ready  = 1'b1;
            bus_size16 = (ncyc == 0) ? s1 : s2;
            bus_din    = (ncyc == 0) ? D1 : D2;
            ncyc++;
         end else begin
            bus_ready = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
      end
      bus_ready = 1'b0;
      bus_size16 = 1'b0;
      bus_din = '0;
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] prev_rd;
      repeat (3) @(negedge clk);
      // R1
      chk(!bus_cyc && !done && bus_be == 0 && !bus_wr, "R1 state during reset",
          {bus_cyc, done, bus_wr, 25'h0, bus_be}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_cyc && !done && rdata == 0, "R1 state after release", rdata, 32'h0);

      prev_rd = 32'h0;
      for (int i = 0; i < NV; i++) begin
         logic [3:0]  v_be;
         logic        v_wr, v_s1, v_s2;
         logic [1:0]  v_n;
         logic [31:0] v_rd, v_wd;
         {v_be, v_wr, v_s1, v_s2, v_n, v_rd, v_wd} = TBL[i];
         xfer(v_be, v_wr, v_s1, v_s2, v_wd);
         chk(done == 1'b1, "R9 done after last cycle", {31'h0, done}, 32'h1);
         chk(ncyc == int'(v_n), "R3 R4 R5 R6 bus cycle count", ncyc, {30'h0, v_n});
         if (!v_wr) begin
            chk(rdata == v_rd, "R8 R9 R10 R11 assembled read data", rdata, v_rd);
            prev_rd = v_rd;
         end else begin
            chk(rdata == prev_rd, "R9 read data kept across write", rdata, prev_rd);
         end
         @(negedge clk);
         chk(!done, "R9 done is a single pulse", {31'h0, done}, 32'h0);
      end

      // R3 and R12: wait clocks with size flipping and a request raised while busy
      @(negedge clk);
      req_valid = 1'b1; req_be = 4'hF; req_write = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_be = 4'h3;
      bus_ready = 1'b0; bus_size16 = 1'b1; bus_din = D2;
      @(posedge clk);
      @(negedge clk);
      chk(bus_cyc && bus_be == 4'hF, "R12 busy request leaves cycle unchanged",
          {28'h0, bus_be}, 32'hF);
      req_valid = 1'b0;
      bus_size16 = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_ready = 1'b1; bus_size16 = 1'b0; bus_din = D1;
      @(posedge clk);
      @(negedge clk);
      bus_ready = 1'b0;
      chk(done && !bus_cyc, "R3 size seen only at ready, one cycle",
          {30'h0, done, bus_cyc}, 32'h2);
      chk(rdata == D1, "R3 wide read data", rdata, D1);
      @(negedge clk);
      chk(!bus_cyc, "R12 busy request not queued", {31'h0, bus_cyc}, 32'h0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule